// File: doc/BRIEF.md
# Keyboard/Mouse Host Interrupt Generator

This block drives the two host interrupt lines of a legacy keyboard-controller style interface, one for the keyboard and one for the mouse. Firmware loads output data through either a keyboard data register or a mouse data register. Each load sets one output-buffer-full flag that both channels share, and a host read of the buffer clears it. The data register written last decides which of the two lines the interrupt appears on.

Each line has its own hardware-enable bit. With the bit clear, firmware drives the line directly through a software level bit. With it set, the line is generated from the full flag, either as a level or as one low-going pulse whose width firmware chooses. A single inversion bit flips the polarity of the generated lines. Each line's present value is also available as a readback bit.

Top module: `kbm_irq_gen`

## Requirements
- R1: With its hardware-enable bit at 0, a line equals its software level bit, and each line is handled on its own. Bit 0 of each two-bit control field belongs to the keyboard and bit 1 to the mouse.
- R2: In level mode (mode field 0) with normal polarity, the routed line is 1 from the cycle after a data write until the cycle after a host read. A data write and a host read in the same cycle leave the flag set.
- R3: In edge mode with normal polarity, a generated line rests at 1. A set of the full flag drives one low pulse, which starts two cycles after the data write. Later cycles with the flag still set start no further pulse.
- R4: Mode field values 1, 2 and 3 give pulse widths of 1, 2 and 4 clock cycles.
- R5: A keyboard data write routes the interrupt to the keyboard line and a mouse data write routes it to the mouse line. The line that is not routed stays at its inactive level, so the two are never active together.
- R6: With the inversion bit at 1, both hardware-generated lines are the exact inverse of their normal-polarity values.
- R7: The readback bits always equal the current interrupt lines.
- R8: A synchronous reset clears the full flag, any running pulse, the hardware enables and the software level bits, and routes to the keyboard. After reset both lines read 0.
- R9: A host read during a pulse does not shorten the pulse.
- R10: Control fields presented with the control write strobe take effect on the lines in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_data_wr | input | 1 | Keyboard output data register write strobe |
| mou_data_wr | input | 1 | Mouse output data register write strobe |
| host_rd | input | 1 | Host read of the output buffer, clears the full flag |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_hw_en | input | 2 | Hardware-enable bits (bit 0 keyboard, bit 1 mouse) |
| ctrl_sw_lvl | input | 2 | Software level bits (bit 0 keyboard, bit 1 mouse) |
| ctrl_mode | input | 2 | 0 level, 1/2/3 edge with 1/2/4-cycle pulse |
| ctrl_inv | input | 1 | Polarity inversion of generated lines |
| irq_kbd | output | 1 | Keyboard interrupt line |
| irq_mou | output | 1 | Mouse interrupt line |
| rb_kbd | output | 1 | Readback of keyboard line |
| rb_mou | output | 1 | Readback of mouse line |

## Verification
A control write and a level change from a data write or host read appear on the lines one cycle after the strobe. An edge pulse starts two cycles after the data write and lasts the programmed 1, 2 or 4 cycles. The driver queues one expected pair of line values for every cycle it drives, and the monitor takes that pair 2 ns after the next rising edge. Because each expectation sits at the exact cycle offset, a pulse that is late, early, too long or too short shows up as a mismatch.

// File: rtl/kbm_irq_pkg.sv
package kbm_irq_pkg;

    localparam int NCH    = 2;
    localparam int MODE_W = 2;

    localparam int MAX_PULSE = 1 << ((1 << MODE_W) - 2);
    localparam int CNT_W     = $clog2(MAX_PULSE + 1);

    typedef enum logic [0:0] {
        CH_KBD = 1'b0,
        CH_MOU = 1'b1
    } chan_e;

    typedef struct packed {
        logic              inv;
        logic [MODE_W-1:0] mode;
        logic [NCH-1:0]    sw_lvl;
        logic [NCH-1:0]    hw_en;
    } irq_cfg_t;

    function automatic logic [CNT_W-1:0] pulse_len(input logic [MODE_W-1:0] m);
        logic [CNT_W-1:0] r;
        r = '0;
        if (m != '0) begin
            r = CNT_W'(1) << (m - 1'b1);
        end
        return r;
    endfunction

endpackage

// File: rtl/kbm_cfg_reg.sv
module kbm_cfg_reg
    import kbm_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  irq_cfg_t wdata,
    output irq_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/kbm_obf_track.sv
module kbm_obf_track
    import kbm_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  kbd_wr,
    input  logic  mou_wr,
    input  logic  host_rd,
    output logic  obf,
    output chan_e route,
    output logic  set_evt
);

    logic obf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            obf   <= 1'b0;
            obf_q <= 1'b0;
            route <= CH_KBD;
        end else begin
            obf_q <= obf;
            if (kbd_wr || mou_wr) begin
                obf <= 1'b1;
            end else if (host_rd) begin
                obf <= 1'b0;
            end
            if (kbd_wr) begin
                route <= CH_KBD;
            end else if (mou_wr) begin
                route <= CH_MOU;
            end
        end
    end

    assign set_evt = obf && !obf_q;

endmodule

// File: rtl/kbm_pulse_timer.sv
module kbm_pulse_timer
    import kbm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [MODE_W-1:0] mode,
    input  chan_e             chan_in,
    output logic              pulse_on,
    output chan_e             pulse_ch
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pulse_ch <= CH_KBD;
        end else if (fire && (mode != '0)) begin
            cnt      <= pulse_len(mode);
            pulse_ch <= chan_in;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pulse_on = (cnt != '0);

endmodule

// File: rtl/kbm_line_drv.sv
module kbm_line_drv (
    input  logic hw_en,
    input  logic sw_lvl,
    input  logic level_mode,
    input  logic inv,
    input  logic obf_sel,
    input  logic pulse_sel,
    output logic line
);

    logic norm;

    always_comb begin
        norm = level_mode ? obf_sel : !pulse_sel;
        line = hw_en ? (norm ^ inv) : sw_lvl;
    end

endmodule

// File: rtl/kbm_irq_gen.sv
module kbm_irq_gen
    import kbm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kbd_data_wr,
    input  logic              mou_data_wr,
    input  logic              host_rd,
    input  logic              ctrl_we,
    input  logic [NCH-1:0]    ctrl_hw_en,
    input  logic [NCH-1:0]    ctrl_sw_lvl,
    input  logic [MODE_W-1:0] ctrl_mode,
    input  logic              ctrl_inv,
    output logic              irq_kbd,
    output logic              irq_mou,
    output logic              rb_kbd,
    output logic              rb_mou
);

    irq_cfg_t       cfg_wdata;
    irq_cfg_t       cfg_q;
    logic           obf;
    chan_e          route;
    logic           set_evt;
    logic           pulse_on;
    chan_e          pulse_ch;
    logic [NCH-1:0] line_vec;

    always_comb begin
        cfg_wdata.inv    = ctrl_inv;
        cfg_wdata.mode   = ctrl_mode;
        cfg_wdata.sw_lvl = ctrl_sw_lvl;
        cfg_wdata.hw_en  = ctrl_hw_en;
    end

    kbm_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    kbm_obf_track u_obf (
        .clk     (clk),
        .rst     (rst),
        .kbd_wr  (kbd_data_wr),
        .mou_wr  (mou_data_wr),
        .host_rd (host_rd),
        .obf     (obf),
        .route   (route),
        .set_evt (set_evt)
    );

    kbm_pulse_timer u_pulse (
        .clk      (clk),
        .rst      (rst),
        .fire     (set_evt),
        .mode     (cfg_q.mode),
        .chan_in  (route),
        .pulse_on (pulse_on),
        .pulse_ch (pulse_ch)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_line
        kbm_line_drv u_drv (
            .hw_en      (cfg_q.hw_en[ch]),
            .sw_lvl     (cfg_q.sw_lvl[ch]),
            .level_mode (cfg_q.mode == '0),
            .inv        (cfg_q.inv),
            .obf_sel    (obf && (route == chan_e'(ch))),
            .pulse_sel  (pulse_on && (pulse_ch == chan_e'(ch))),
            .line       (line_vec[ch])
        );
    end

    assign irq_kbd = line_vec[CH_KBD];
    assign irq_mou = line_vec[CH_MOU];
    assign rb_kbd  = line_vec[CH_KBD];
    assign rb_mou  = line_vec[CH_MOU];

endmodule

// File: rtl/kbm_irq_chk.sv
module kbm_irq_chk
    import kbm_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              kbd_data_wr,
    input logic              mou_data_wr,
    input logic              host_rd,
    input logic              ctrl_we,
    input logic [NCH-1:0]    ctrl_hw_en,
    input logic [NCH-1:0]    ctrl_sw_lvl,
    input logic              irq_kbd,
    input logic              irq_mou,
    input irq_cfg_t          cfg_q,
    input logic              pulse_on
);

    logic [CNT_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (pulse_on) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    logic lvl_norm_all;
    assign lvl_norm_all = (cfg_q.hw_en == 2'b11) && (cfg_q.mode == '0) && !cfg_q.inv;

    p_sw_line_r1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_hw_en[0]) |=> (irq_kbd == $past(ctrl_sw_lvl[0])));

    p_level_set_r2: assert property (@(posedge clk) disable iff (rst)
        (lvl_norm_all && !ctrl_we && kbd_data_wr) |=> (irq_kbd && !irq_mou));

    p_level_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (lvl_norm_all && !ctrl_we && host_rd && !kbd_data_wr && !mou_data_wr)
        |=> (!irq_kbd && !irq_mou));

    p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        lvl_norm_all |-> !(irq_kbd && irq_mou));

    p_edge_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q.hw_en == 2'b11) && (cfg_q.mode != '0) && !cfg_q.inv)
        |-> (irq_kbd || irq_mou));

    p_pulse_bound_r4: assert property (@(posedge clk) disable iff (rst)
        run_len <= (CNT_W+1)'(MAX_PULSE));

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!irq_kbd && !irq_mou));

endmodule

bind kbm_irq_gen kbm_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .kbd_data_wr (kbd_data_wr),
    .mou_data_wr (mou_data_wr),
    .host_rd     (host_rd),
    .ctrl_we     (ctrl_we),
    .ctrl_hw_en  (ctrl_hw_en),
    .ctrl_sw_lvl (ctrl_sw_lvl),
    .irq_kbd     (irq_kbd),
    .irq_mou     (irq_mou),
    .cfg_q       (cfg_q),
    .pulse_on    (pulse_on)
);

// File: tb/kbm_irq_gen_test.sv
module kbm_irq_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kbd_data_wr = 1'b0;
    logic       mou_data_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [1:0] ctrl_hw_en = 2'b00;
    logic [1:0] ctrl_sw_lvl = 2'b00;
    logic [1:0] ctrl_mode = 2'b00;
    logic       ctrl_inv = 1'b0;
    logic       irq_kbd, irq_mou, rb_kbd, rb_mou;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic  k;
        logic  m;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    kbm_irq_gen uut (
        .clk         (clk),
        .rst         (rst),
        .kbd_data_wr (kbd_data_wr),
        .mou_data_wr (mou_data_wr),
        .host_rd     (host_rd),
        .ctrl_we     (ctrl_we),
        .ctrl_hw_en  (ctrl_hw_en),
        .ctrl_sw_lvl (ctrl_sw_lvl),
        .ctrl_mode   (ctrl_mode),
        .ctrl_inv    (ctrl_inv),
        .irq_kbd     (irq_kbd),
        .irq_mou     (irq_mou),
        .rb_kbd      (rb_kbd),
        .rb_mou      (rb_mou)
    );

    // monitor: one expected item per driven cycle, sampled 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (irq_kbd !== e.k || irq_mou !== e.m) begin
                    n_fail++;
                    $display("FAIL %s lines kbd/mou actual %b%b expected %b%b",
                             e.tag, irq_kbd, irq_mou, e.k, e.m);
                end
                n_tests++;
                if (rb_kbd !== irq_kbd || rb_mou !== irq_mou) begin
                    n_fail++;
                    $display("FAIL R7 readback actual %b%b expected %b%b",
                             rb_kbd, rb_mou, irq_kbd, irq_mou);
                end
            end
        end
    end

    task automatic push(input logic k, input logic m, input string tag);
        exp_t e;
        e.k = k; e.m = m; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input logic kw, input logic mw, input logic rd,
                        input logic ek, input logic em, input string tag);
        @(negedge clk);
        rst = 1'b0; ctrl_we = 1'b0;
        kbd_data_wr = kw; mou_data_wr = mw; host_rd = rd;
        push(ek, em, tag);
    endtask

    task automatic cfg(input logic [1:0] hw, input logic [1:0] sw, input logic [1:0] md,
                       input logic inv, input logic ek, input logic em, input string tag);
        @(negedge clk);
        rst = 1'b0; ctrl_we = 1'b1;
        kbd_data_wr = 1'b0; mou_data_wr = 1'b0; host_rd = 1'b0;
        ctrl_hw_en = hw; ctrl_sw_lvl = sw; ctrl_mode = md; ctrl_inv = inv;
        push(ek, em, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ctrl_we = 1'b0;
        kbd_data_wr = 1'b0; mou_data_wr = 1'b0; host_rd = 1'b0;
        push(1'b0, 1'b0, "R8 reset");
    endtask

    initial begin
        do_reset();
        do_reset();
        step(0, 0, 0, 0, 0, "R8 after reset");
        // R1 / R10: software-driven lines
        cfg(2'b00, 2'b10, 2'd0, 1'b0, 0, 1, "R1 R10 sw mouse");
        cfg(2'b00, 2'b01, 2'd0, 1'b0, 1, 0, "R1 sw keyboard");
        cfg(2'b00, 2'b00, 2'd0, 1'b0, 0, 0, "R1 sw off");
        // R2 / R5: level mode, normal polarity
        cfg(2'b11, 2'b00, 2'd0, 1'b0, 0, 0, "R2 level idle");
        step(1, 0, 0, 1, 0, "R2 R5 kbd write");
        step(0, 0, 0, 1, 0, "R2 held");
        step(0, 0, 1, 0, 0, "R2 host read");
        step(0, 1, 0, 0, 1, "R5 mouse write");
        step(1, 0, 0, 1, 0, "R5 reroute to kbd");
        step(0, 0, 1, 0, 0, "R2 host read");
        // R6: inverted level
        cfg(2'b11, 2'b00, 2'd0, 1'b1, 1, 1, "R6 inv idle");
        step(1, 0, 0, 0, 1, "R6 inv kbd write");
        step(0, 0, 1, 1, 1, "R6 inv read");
        // R3 / R4: edge width 1
        cfg(2'b11, 2'b00, 2'd1, 1'b0, 1, 1, "R3 edge rest");
        step(1, 0, 0, 1, 1, "R3 write no pulse yet");
        step(0, 0, 0, 0, 1, "R3 R4 pulse w1");
        step(0, 0, 0, 1, 1, "R4 pulse w1 end");
        step(0, 0, 0, 1, 1, "R3 single pulse");
        step(0, 0, 1, 1, 1, "R3 read");
        // R4: edge width 2 on mouse
        cfg(2'b11, 2'b00, 2'd2, 1'b0, 1, 1, "R4 edge rest");
        step(0, 1, 0, 1, 1, "R4 mouse write");
        step(0, 0, 0, 1, 0, "R4 w2 c1");
        step(0, 0, 0, 1, 0, "R4 w2 c2");
        step(0, 0, 0, 1, 1, "R4 w2 end");
        step(0, 0, 1, 1, 1, "R4 read");
        // R4 / R9: edge width 4 with read mid-pulse
        cfg(2'b11, 2'b00, 2'd3, 1'b0, 1, 1, "R4 edge rest");
        step(1, 0, 0, 1, 1, "R4 kbd write");
        step(0, 0, 0, 0, 1, "R4 w4 c1");
        step(0, 0, 1, 0, 1, "R9 read mid pulse");
        step(0, 0, 0, 0, 1, "R9 w4 c3");
        step(0, 0, 0, 0, 1, "R9 w4 c4");
        step(0, 0, 0, 1, 1, "R4 w4 end");
        // R6: inverted edge
        cfg(2'b11, 2'b00, 2'd1, 1'b1, 0, 0, "R6 inv edge rest");
        step(0, 1, 0, 0, 0, "R6 mouse write");
        step(0, 0, 0, 0, 1, "R6 inv pulse");
        step(0, 0, 0, 0, 0, "R6 inv pulse end");
        step(0, 0, 1, 0, 0, "R6 read");
        // R1: per-line independence
        cfg(2'b01, 2'b10, 2'd0, 1'b0, 0, 1, "R1 mixed");
        step(1, 0, 0, 1, 1, "R1 kbd hw mouse sw");
        step(0, 0, 1, 0, 1, "R1 read");
        // R2: write and read together
        cfg(2'b11, 2'b00, 2'd0, 1'b0, 0, 0, "R2 level idle");
        step(1, 0, 1, 1, 0, "R2 write beats read");
        step(0, 0, 1, 0, 0, "R2 read");
        // R8: reset mid-operation
        cfg(2'b11, 2'b00, 2'd1, 1'b0, 1, 1, "R3 edge rest");
        step(1, 0, 0, 1, 1, "R3 write");
        do_reset();
        step(0, 0, 0, 0, 0, "R8 no pulse after reset");
        cfg(2'b11, 2'b00, 2'd0, 1'b0, 0, 0, "R8 flag cleared");
        step(0, 0, 0, 0, 0, "R8 idle");
        repeat (3) @(posedge clk);
        #3;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule